// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block takes one fast clock and produces two divided clocks, called bank A and bank B. A single 3-bit select word sets the divide ratio of both banks at once. Each bank divides by 2, 4 or 5, and every ratio gives a duty cycle of 50%. The odd ratio reaches 50% because its high phase is stretched by half an input period, using a flop clocked on the falling edge. Bank A drives two complementary pairs that are always identical. Bank B drives one complementary pair.

An active-high master reset holds the counters at zero and forces every true output high and every complement output low. When reset is released, both banks count from the same input edge, so their rising edges coincide once per common period. A separate enable for each bank releases that bank's pins to high impedance. A new select word is taken up by each bank only when that bank's count wraps to zero, so a ratio change never produces a shortened pulse.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: `ratio_sel`, read as an unsigned number, sets the ratio pair (A, B) as follows: 0→(2,2), 1→(2,5), 2→(4,2), 3→(4,5), 4→(5,2), 5→(5,4), 6→(2,4), 7→(4,4). Select 0 is the default pair, with both banks dividing by 2.
- R2: While `mr` is high, every true output is 1 and every complement output is 0 on an enabled bank. This forcing takes effect at once, without waiting for a clock edge, and both counters sit at zero.
- R3: Call the last rising edge of `clk_vco` with `mr` high count zero. A bank with ratio N begins its next high phase on the Nth rising edge after that edge. Both banks therefore rise on the same edge at the least common multiple of their ratios.
- R4: With ratio 2 or 4, the output is high for N/2 input cycles, starting at a rising edge, and the period is N input cycles.
- R5: With ratio 5, the output is high for 2.5 input cycles and low for 2.5 input cycles. The high phase starts on a rising edge and ends on a falling edge.
- R6: On an enabled bank, each complement output is the inverse of its true output. The two bank A pairs carry identical values at all times.
- R7: When `oe_a` is low, all four bank A pins are high impedance. When `oe_b` is low, both bank B pins are high impedance. Each enable acts only on its own bank.
- R8: A change of `ratio_sel` while running takes effect in each bank only at that bank's next count-zero boundary. Every complete high or low phase has the full length of either the old ratio or the new one.
- R9: A bank's counter always stays below its active ratio, and the active ratio is always 2, 4 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock to be divided |
| mr | input | 1 | Active-high master reset, synchronous to `clk_vco` |
| ratio_sel | input | 3 | Joint ratio select word for both banks |
| oe_a | input | 1 | Bank A output enable (low gives high impedance) |
| oe_b | input | 1 | Bank B output enable (low gives high impedance) |
| qa0 | output | 1 | Bank A pair 0, true |
| nqa0 | output | 1 | Bank A pair 0, complement |
| qa1 | output | 1 | Bank A pair 1, true |
| nqa1 | output | 1 | Bank A pair 1, complement |
| qb | output | 1 | Bank B, true |
| nqb | output | 1 | Bank B, complement |

## Verification
The block has no parameters, so the bench builds it exactly as delivered. It sweeps all eight select words and compares every half-cycle sample of both banks against a waveform computed from the count origin. This covers the 2.5-cycle phases of the odd ratio, the coincident rising edges at the least common multiple, and period and high time for every ratio. The bench also applies all four enable combinations, using pull resistors on the bench nets so that high impedance reads back as a known level. A mid-run select change checks that every complete pulse keeps a legal length.

// File: rtl/dual_bank_clkdiv.sv
module dual_bank_clkdiv (
  input  logic       clk_vco,
  input  logic       mr,
  input  logic [2:0] ratio_sel,
  input  logic       oe_a,
  input  logic       oe_b,
  output logic       qa0,
  output logic       nqa0,
  output logic       qa1,
  output logic       nqa1,
  output logic       qb,
  output logic       nqb
);

  function automatic logic [5:0] pair_of(input logic [2:0] s);
    case (s)
      3'd0:    return {3'd2, 3'd2};
      3'd1:    return {3'd2, 3'd5};
      3'd2:    return {3'd4, 3'd2};
      3'd3:    return {3'd4, 3'd5};
      3'd4:    return {3'd5, 3'd2};
      3'd5:    return {3'd5, 3'd4};
      3'd6:    return {3'd2, 3'd4};
      default: return {3'd4, 3'd4};
    endcase
  endfunction

  logic [5:0] want;
  logic [5:0] cnt_all;
  logic [5:0] n_all;
  logic [1:0] hi_all;
  logic [1:0] lvl;

  assign want = pair_of(ratio_sel);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [2:0] cnt, n_r, nxt, n_sel;
    logic       hi_r, fall_r;

    assign n_sel = (g == 0) ? want[5:3] : want[2:0];
    assign nxt   = (cnt == n_r - 3'd1) ? 3'd0 : cnt + 3'd1;

    always_ff @(posedge clk_vco) begin
      if (mr) begin
        cnt  <= 3'd0;
        n_r  <= n_sel;
        hi_r <= 1'b1;
      end else begin
        cnt  <= nxt;
        hi_r <= nxt < (n_r >> 1);
        if (nxt == 3'd0) n_r <= n_sel;
      end
    end

    always_ff @(negedge clk_vco) fall_r <= hi_r;

    assign lvl[g]               = mr | hi_r | (n_r[0] & fall_r);
    assign cnt_all[g*3 +: 3]    = cnt;
    assign n_all[g*3 +: 3]      = n_r;
    assign hi_all[g]            = hi_r;
  end

  assign qa0  = oe_a ? lvl[0]  : 1'bz;
  assign nqa0 = oe_a ? ~lvl[0] : 1'bz;
  assign qa1  = oe_a ? lvl[0]  : 1'bz;
  assign nqa1 = oe_a ? ~lvl[0] : 1'bz;
  assign qb   = oe_b ? lvl[1]  : 1'bz;
  assign nqb  = oe_b ? ~lvl[1] : 1'bz;

endmodule

module dual_bank_clkdiv_chk (
  input logic       clk_vco,
  input logic       mr,
  input logic [5:0] cnt_all,
  input logic [5:0] n_all,
  input logic [1:0] hi_all
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_cnt_bound_R9: assert property (@(posedge clk_vco) disable iff (mr)
      cnt_all[g*3 +: 3] < n_all[g*3 +: 3]);
    assert_legal_ratio_R9: assert property (@(posedge clk_vco) disable iff (mr)
      (n_all[g*3 +: 3] == 3'd2) || (n_all[g*3 +: 3] == 3'd4) || (n_all[g*3 +: 3] == 3'd5));
    assert_ratio_at_wrap_R8: assert property (@(posedge clk_vco) disable iff (mr)
      !$stable(n_all[g*3 +: 3]) |-> (cnt_all[g*3 +: 3] == 3'd0));
    assert_rise_at_zero_R3: assert property (@(posedge clk_vco) disable iff (mr)
      $rose(hi_all[g]) |-> (cnt_all[g*3 +: 3] == 3'd0));
    assert_hold_after_reset_R2: assert property (@(posedge clk_vco) disable iff (!mr)
      $past(mr) |-> (cnt_all[g*3 +: 3] == 3'd0));
  end
endmodule

bind dual_bank_clkdiv dual_bank_clkdiv_chk u_chk (
  .clk_vco(clk_vco), .mr(mr), .cnt_all(cnt_all), .n_all(n_all), .hi_all(hi_all));

// File: tb/dual_bank_clkdiv_test.sv
module dual_bank_clkdiv_test;
  localparam int CLK_P = 10;
  localparam int STEPS = 160;

  logic clk = 1'b0;
  logic mr = 1'b1;
  logic [2:0] sel = 3'd0;
  logic oea = 1'b1, oeb = 1'b1;
  wire qa0_w, nqa0_w, qa1_w, nqa1_w, qb_w, nqb_w;

  pulldown (qa0_w);
  pullup   (nqa0_w);
  pulldown (qa1_w);
  pullup   (nqa1_w);
  pulldown (qb_w);
  pullup   (nqb_w);

  int errors = 0;
  int checks = 0;
  logic sa [STEPS];
  logic sb [STEPS];
  int bad_pair;

  always #(CLK_P/2) clk = ~clk;

  dual_bank_clkdiv uut (
    .clk_vco(clk), .mr(mr), .ratio_sel(sel), .oe_a(oea), .oe_b(oeb),
    .qa0(qa0_w), .nqa0(nqa0_w), .qa1(qa1_w), .nqa1(nqa1_w), .qb(qb_w), .nqb(nqb_w));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ra(input logic [2:0] s);
    case (s)
      3'd2, 3'd3, 3'd7: return 4;
      3'd4, 3'd5:       return 5;
      default:          return 2;
    endcase
  endfunction

  function automatic int rb(input logic [2:0] s);
    case (s)
      3'd1, 3'd3:       return 5;
      3'd5, 3'd6, 3'd7: return 4;
      default:          return 2;
    endcase
  endfunction

  function automatic logic exp_lvl(input int n, input int k);
    int j = k / 2;
    int c = (j + 1) % n;
    if (n == 5) return (k % 2 == 0) ? ((c < 2) || ((j % n) < 2)) : (c < 2);
    return c < n / 2;
  endfunction

  function automatic int lcm(input int x, input int y);
    for (int m = 1; m <= x * y; m++) if (m % x == 0 && m % y == 0) return m;
    return x * y;
  endfunction

  task automatic reset_with(input logic [2:0] s);
    @(negedge clk);
    mr = 1'b1;
    sel = s;
    repeat (3) @(negedge clk);
  endtask

  task automatic capture();
    bad_pair = 0;
    for (int k = 0; k < STEPS; k++) begin
      if (k % 2 == 0) @(posedge clk); else @(negedge clk);
      #1;
      sa[k] = qa0_w;
      sb[k] = qb_w;
      if (oea && (qa1_w !== qa0_w || nqa0_w !== ~qa0_w || nqa1_w !== ~qa0_w)) bad_pair++;
      if (oeb && nqb_w !== ~qb_w) bad_pair++;
    end
  endtask

  task automatic run_code(input logic [2:0] s);
    int na, nb, bad_a, bad_b, ha, hb, pa, pb, st, l;
    oea = 1'b1; oeb = 1'b1;
    reset_with(s);
    #1;
    chk(qa0_w === 1'b1 && qa1_w === 1'b1 && qb_w === 1'b1, "R2 true outputs high in reset",
        int'(qa0_w & qa1_w & qb_w), 1);
    chk(nqa0_w === 1'b0 && nqa1_w === 1'b0 && nqb_w === 1'b0, "R2 complement outputs low in reset",
        int'(nqa0_w | nqa1_w | nqb_w), 0);
    @(negedge clk);
    mr = 1'b0;
    capture();
    na = ra(s); nb = rb(s);
    bad_a = 0; bad_b = 0;
    for (int k = 0; k < STEPS; k++) begin
      if (sa[k] !== exp_lvl(na, k)) bad_a++;
      if (sb[k] !== exp_lvl(nb, k)) bad_b++;
    end
    chk(bad_a == 0, $sformatf("R1 bank A waveform sel=%0d mismatched steps", s), bad_a, 0);
    chk(bad_b == 0, $sformatf("R1 bank B waveform sel=%0d mismatched steps", s), bad_b, 0);
    chk(bad_pair == 0, $sformatf("R6 pair complement/equality sel=%0d", s), bad_pair, 0);
    ha = 0; hb = 0; pa = 0; pb = 0;
    for (int k = 4 * na; k < 6 * na; k++) begin
      ha += int'(sa[k]);
      if (sa[k] !== sa[k + 2 * na]) pa++;
    end
    for (int k = 4 * nb; k < 6 * nb; k++) begin
      hb += int'(sb[k]);
      if (sb[k] !== sb[k + 2 * nb]) pb++;
    end
    chk(ha == na, $sformatf("%s bank A high half-cycles sel=%0d", na == 5 ? "R5" : "R4", s), ha, na);
    chk(hb == nb, $sformatf("%s bank B high half-cycles sel=%0d", nb == 5 ? "R5" : "R4", s), hb, nb);
    chk(pa == 0, $sformatf("R4 bank A period %0d cycles sel=%0d", na, s), pa, 0);
    chk(pb == 0, $sformatf("R4 bank B period %0d cycles sel=%0d", nb, s), pb, 0);
    l = lcm(na, nb);
    st = 2 * (l - 1);
    chk(sa[st] === 1'b1 && sa[st-1] === 1'b0 && sb[st] === 1'b1 && sb[st-1] === 1'b0,
        $sformatf("R3 joint rising edge at cycle %0d sel=%0d", l, s),
        int'({sa[st-1], sa[st], sb[st-1], sb[st]}), 5);
  endtask

  task automatic run_enable(input logic a_on, input logic b_on);
    int bad;
    oea = a_on; oeb = b_on;
    reset_with(3'd5);
    #1;
    chk(qa0_w === a_on && nqa0_w === ~a_on && qa1_w === a_on && nqa1_w === ~a_on,
        $sformatf("R7 bank A pins in reset oe_a=%0d", a_on), int'(qa0_w), int'(a_on));
    chk(qb_w === b_on && nqb_w === ~b_on,
        $sformatf("R7 bank B pins in reset oe_b=%0d", b_on), int'(qb_w), int'(b_on));
    @(negedge clk);
    mr = 1'b0;
    capture();
    bad = 0;
    for (int k = 0; k < STEPS; k++) begin
      if (sa[k] !== (a_on ? exp_lvl(5, k) : 1'b0)) bad++;
      if (sb[k] !== (b_on ? exp_lvl(4, k) : 1'b0)) bad++;
    end
    chk(bad == 0, $sformatf("R7 running outputs oe_a=%0d oe_b=%0d", a_on, b_on), bad, 0);
    if (!a_on) chk(nqa0_w === 1'b1 && nqa1_w === 1'b1 && qa1_w === 1'b0,
        "R7 bank A complement pins released", int'(nqa0_w), 1);
    if (!b_on) chk(nqb_w === 1'b1, "R7 bank B complement pin released", int'(nqb_w), 1);
  endtask

  task automatic run_switch();
    int run, bad_a, bad_b, first;
    oea = 1'b1; oeb = 1'b1;
    reset_with(3'd0);
    @(negedge clk);
    mr = 1'b0;
    repeat (7) @(negedge clk);
    sel = 3'd5;
    capture();
    bad_a = 0; run = 1; first = 1;
    for (int k = 1; k < STEPS; k++) begin
      if (sa[k] === sa[k-1]) run++;
      else begin
        if (!first && run != 2 && run != 5) bad_a++;
        first = 0; run = 1;
      end
    end
    bad_b = 0; run = 1; first = 1;
    for (int k = 1; k < STEPS; k++) begin
      if (sb[k] === sb[k-1]) run++;
      else begin
        if (!first && run != 2 && run != 4) bad_b++;
        first = 0; run = 1;
      end
    end
    chk(bad_a == 0, "R8 bank A pulse lengths across switch 2->5", bad_a, 0);
    chk(bad_b == 0, "R8 bank B pulse lengths across switch 2->4", bad_b, 0);
    bad_a = 0; bad_b = 0;
    for (int k = STEPS - 40; k < STEPS - 10; k++) begin
      if (sa[k] !== sa[k+10]) bad_a++;
      if (sb[k] !== sb[k+8]) bad_b++;
    end
    chk(bad_a == 0, "R8 bank A settles to ratio 5", bad_a, 0);
    chk(bad_b == 0, "R8 bank B settles to ratio 4", bad_b, 0);
    @(negedge clk);
    mr = 1'b1;
    #1;
    chk(qa0_w === 1'b1 && qb_w === 1'b1 && nqb_w === 1'b0, "R2 immediate force on mid-run reset",
        int'(qa0_w & qb_w), 1);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) run_code(3'(s));
    for (int e = 0; e < 4; e++) run_enable(e[1], e[0]);
    run_switch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule